// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the write-side controller of a parallel NOR flash model that follows the common two-cycle unlock command protocol. Every bus write cycle carries a byte address and a data word. The low byte of the data word is the command byte. The sequencer decodes unlock pairs and command bytes, and it applies word program, sector erase and chip erase to an internal cell array. It also supports an unlock bypass mode, in which command cycles need no unlock pair, and it can enter autoselect and CFI query modes.

Its current sequencing state and an eight-bit status byte are exported so that a separate read-path block can decide what a read returns. A combinational read port gives that block the array contents. An erase keeps the device busy for a parameterised number of clock cycles, and chip erase has its own duration. A read-only input freezes the array while the command sequencing carries on as usual.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is asserted and after it is released, the state code is 0 (read), bypass is 0, busy is 0, the status byte is 0x00 and every array word is all ones.
- R2: State codes are read=0, second unlock=1, command=2, program data=3, autoselect=4, erase first unlock=5, erase second unlock=6, erase command=7, erasing=8, CFI query=9. From read, 0xAA at unlock offset 0 gives code 1. Then 0x55 at unlock offset 1 gives code 2. A mismatch in either cycle returns to code 0 and clears bypass.
- R3: Outside bypass, the command cycle must target unlock offset 0. There, 0xA0 selects program (3), 0x90 selects autoselect (4), 0x80 selects erase setup (5) and 0x20 sets bypass and stays at code 2. A wrong offset or any other byte returns to read and clears bypass.
- R4: The word offset compared against the unlock offsets is (byte address mod sector size) shifted right by log2 of the device width in bytes. The low address bits and the sector number therefore play no part in the comparison.
- R5: A write of 0x98 at word offset 0x55, made in read or autoselect, enters CFI query (9). Any write made in CFI query returns to read.
- R6: A command byte of 0xF0 returns to read and clears bypass from any state except program data (3). In program data, 0xF0 is stored as ordinary data. An erase aborted this way leaves the status byte unchanged.
- R7: A program write stores the old word ANDed with the written data word. It then sets the status byte to {~d[7], 7'h7F}, where d[7] is bit 7 of the written data.
- R8: After a program write the state becomes command (2) with bypass kept if bypass is set; otherwise it becomes read (0).
- R9: Erase setup needs a second unlock pair (5 then 6). In code 7, 0x10 at unlock offset 0 erases the whole array to all ones, and 0x30 at any address erases only the sector that holds the address. Anything else returns to read.
- R10: When an erase starts, the status byte becomes 0x00 and busy stays high for exactly SECTOR_ERASE_CYCLES or CHIP_ERASE_CYCLES cycles. Writes other than 0xF0 are ignored during that time. At the end, status bit 7 inverts and the state becomes command if bypass is set, otherwise read.
- R11: In bypass, a command cycle is accepted at any address. The write 0x90 followed by 0x00 leaves bypass and returns to read.
- R12: While read_only is high the array does not change, but states and the status byte follow R2 to R11.
- R13: rd_data gives the array word at byte address rd_addr shifted right by log2 of the device width, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; low byte is the command byte |
| read_only | input | 1 | Freezes array contents |
| rd_addr | input | ADDR_W | Byte address for the array read port |
| rd_data | output | DATA_W | Array word at rd_addr |
| seq_state | output | 4 | Current sequencing state code |
| bypass_active | output | 1 | Unlock bypass is in effect |
| erase_busy | output | 1 | An erase is in progress |
| status_byte | output | 8 | Status byte for the read path |

## Verification
The bench builds a 16-bit device with four 512-byte sectors, so the word-offset shift is exercised and the unlock offsets 0xAA and 0x55 lie inside one sector. The erase windows are cut to 16 and 40 cycles. This lets both kinds of erase run to completion, so the busy length, the flip of status bit 7 and the return to command under bypass can be observed. With four sectors, the bench can check that a sector erase leaves the words in the other sectors unchanged.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [3:0] {
        ST_READ     = 4'd0,
        ST_UNLOCK2  = 4'd1,
        ST_COMMAND  = 4'd2,
        ST_PROGRAM  = 4'd3,
        ST_AUTOSEL  = 4'd4,
        ST_ESETUP1  = 4'd5,
        ST_ESETUP2  = 4'd6,
        ST_ECOMMAND = 4'd7,
        ST_ERASING  = 4'd8,
        ST_CFI      = 4'd9
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE_SEC,
        OP_ERASE_ALL
    } array_op_e;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_ESETUP   = 8'h80;
    localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_QUERY    = 8'h98;
    localparam logic [7:0] CMD_ABORT    = 8'hF0;
    localparam logic [7:0] CMD_ERASEALL = 8'h10;
    localparam logic [7:0] CMD_ERASESEC = 8'h30;
    localparam logic [7:0] CMD_BYP_EXIT = 8'h00;
    localparam int         QUERY_OFF    = 32'h55;

    function automatic int width_shift(input int wbytes);
        return (wbytes == 4) ? 2 : ((wbytes == 2) ? 1 : 0);
    endfunction

    function automatic logic [7:0] prog_status(input logic d7);
        return {~d7, 7'h7F};
    endfunction

endpackage

// File: rtl/nor_addr_split.sv
module nor_addr_split #(
    parameter int ADDR_W  = 11,
    parameter int SEC_LSB = 9,
    parameter int SHIFT   = 1
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic [ADDR_W-SHIFT-1:0]   word_idx,
    output logic [ADDR_W-SEC_LSB-1:0] sector,
    output logic [SEC_LSB-SHIFT-1:0]  word_off
);
    generate
        if (SHIFT == 0) begin : g_byte_wide
            assign word_idx = addr;
            assign word_off = addr[SEC_LSB-1:0];
        end else begin : g_multi_byte
            assign word_idx = addr[ADDR_W-1:SHIFT];
            assign word_off = addr[SEC_LSB-1:SHIFT];
        end
    endgenerate
    assign sector = addr[ADDR_W-1:SEC_LSB];
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
#(
    parameter int OFF_W      = 8,
    parameter int UNLOCK0    = 32'hAA,
    parameter int UNLOCK1    = 32'h55,
    parameter int SECTOR_CYC = 5000,
    parameter int CHIP_CYC   = 50000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [7:0]       wr_byte,
    input  logic [OFF_W-1:0] word_off,
    output seq_state_e       state,
    output logic             bypass,
    output logic [7:0]       status,
    output array_op_e        op
);
    localparam int MAX_CYC = (CHIP_CYC > SECTOR_CYC) ? CHIP_CYC : SECTOR_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [OFF_W-1:0] OFF_U0  = OFF_W'(UNLOCK0);
    localparam logic [OFF_W-1:0] OFF_U1  = OFF_W'(UNLOCK1);
    localparam logic [OFF_W-1:0] OFF_QRY = OFF_W'(QUERY_OFF);

    seq_state_e       st_n;
    logic             byp_n;
    logic [7:0]       stat_n;
    logic [TMR_W-1:0] tmr, tmr_n;

    logic at_u0, at_u1, query_hit;
    assign at_u0     = (word_off == OFF_U0);
    assign at_u1     = (word_off == OFF_U1);
    assign query_hit = (word_off == OFF_QRY) && (wr_byte == CMD_QUERY);

    always_comb begin
        st_n   = state;
        byp_n  = bypass;
        stat_n = status;
        tmr_n  = tmr;
        op     = OP_NONE;
        if (wr_valid && wr_byte == CMD_ABORT && state != ST_PROGRAM) begin
            st_n  = ST_READ;
            byp_n = 1'b0;
        end else if (state == ST_ERASING) begin
            if (tmr == TMR_W'(1)) begin
                stat_n[7] = ~status[7];
                st_n      = bypass ? ST_COMMAND : ST_READ;
            end else begin
                tmr_n = tmr - TMR_W'(1);
            end
        end else if (wr_valid) begin
            // default on any mismatch: back to read, bypass dropped
            st_n  = ST_READ;
            byp_n = 1'b0;
            unique case (state)
                ST_READ: begin
                    if (query_hit)
                        st_n = ST_CFI;
                    else if (at_u0 && wr_byte == CMD_UNLOCK_A)
                        st_n = ST_UNLOCK2;
                end
                ST_UNLOCK2: begin
                    if (at_u1 && wr_byte == CMD_UNLOCK_B) begin
                        st_n  = ST_COMMAND;
                        byp_n = bypass;
                    end
                end
                ST_COMMAND: begin
                    if (bypass || at_u0) begin
                        byp_n = bypass;
                        unique case (wr_byte)
                            CMD_BYPASS:  begin st_n = ST_COMMAND; byp_n = 1'b1; end
                            CMD_ESETUP:  st_n = ST_ESETUP1;
                            CMD_AUTOSEL: st_n = ST_AUTOSEL;
                            CMD_PROGRAM: st_n = ST_PROGRAM;
                            default:     begin st_n = ST_READ; byp_n = 1'b0; end
                        endcase
                    end
                end
                ST_PROGRAM: begin
                    op     = OP_PROG;
                    stat_n = prog_status(wr_byte[7]);
                    byp_n  = bypass;
                    st_n   = bypass ? ST_COMMAND : ST_READ;
                end
                ST_AUTOSEL: begin
                    if (!(bypass && wr_byte == CMD_BYP_EXIT) && query_hit)
                        st_n = ST_CFI;
                end
                ST_ESETUP1: begin
                    if (at_u0 && wr_byte == CMD_UNLOCK_A) begin
                        st_n  = ST_ESETUP2;
                        byp_n = bypass;
                    end
                end
                ST_ESETUP2: begin
                    if (at_u1 && wr_byte == CMD_UNLOCK_B) begin
                        st_n  = ST_ECOMMAND;
                        byp_n = bypass;
                    end
                end
                ST_ECOMMAND: begin
                    if (wr_byte == CMD_ERASEALL && at_u0) begin
                        op     = OP_ERASE_ALL;
                        st_n   = ST_ERASING;
                        byp_n  = bypass;
                        stat_n = 8'h00;
                        tmr_n  = TMR_W'(CHIP_CYC);
                    end else if (wr_byte == CMD_ERASESEC) begin
                        op     = OP_ERASE_SEC;
                        st_n   = ST_ERASING;
                        byp_n  = bypass;
                        stat_n = 8'h00;
                        tmr_n  = TMR_W'(SECTOR_CYC);
                    end
                end
                default: ; // CFI query and stray codes fall back to read
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_READ;
            bypass <= 1'b0;
            status <= 8'h00;
            tmr    <= '0;
        end else begin
            state  <= st_n;
            bypass <= byp_n;
            status <= stat_n;
            tmr    <= tmr_n;
        end
    end
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array
    import nor_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 10,
    parameter int SEC_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  array_op_e         op,
    input  logic              read_only,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEC_W-1:0]  wr_sector,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    localparam int WORDS   = 1 << IDX_W;
    localparam int WPS_LOG = IDX_W - SEC_W;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '1;
        end else if (!read_only) begin
            unique case (op)
                OP_PROG:      cells[wr_idx] <= cells[wr_idx] & wr_word;
                OP_ERASE_SEC: begin
                    for (int i = 0; i < WORDS; i++)
                        if ((i >> WPS_LOG) == int'(wr_sector)) cells[i] <= '1;
                end
                OP_ERASE_ALL: begin
                    for (int i = 0; i < WORDS; i++) cells[i] <= '1;
                end
                default: ;
            endcase
        end
    end

    assign rd_word = cells[rd_idx];
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int WIDTH_BYTES         = 2,
    parameter int SECTOR_BYTES        = 512,
    parameter int NUM_SECTORS         = 4,
    parameter int UNLOCK0_OFF         = 32'hAA,
    parameter int UNLOCK1_OFF         = 32'h55,
    parameter int SECTOR_ERASE_CYCLES = 5000,
    parameter int CHIP_ERASE_CYCLES   = 50000,
    localparam int DATA_W  = 8 * WIDTH_BYTES,
    localparam int ADDR_W  = $clog2(SECTOR_BYTES * NUM_SECTORS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              read_only,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        seq_state,
    output logic              bypass_active,
    output logic              erase_busy,
    output logic [7:0]        status_byte
);
    localparam int SHIFT   = width_shift(WIDTH_BYTES);
    localparam int SEC_LSB = $clog2(SECTOR_BYTES);
    localparam int IDX_W   = ADDR_W - SHIFT;
    localparam int SEC_W   = ADDR_W - SEC_LSB;
    localparam int OFF_W   = SEC_LSB - SHIFT;

    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [SEC_W-1:0] wr_sector, rd_sector;
    logic [OFF_W-1:0] wr_off, rd_off;
    seq_state_e       state;
    array_op_e        op;

    nor_addr_split #(.ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .SHIFT(SHIFT)) u_wr_split (
        .addr(wr_addr), .word_idx(wr_idx), .sector(wr_sector), .word_off(wr_off)
    );

    nor_addr_split #(.ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .SHIFT(SHIFT)) u_rd_split (
        .addr(rd_addr), .word_idx(rd_idx), .sector(rd_sector), .word_off(rd_off)
    );

    nor_seq_fsm #(
        .OFF_W(OFF_W), .UNLOCK0(UNLOCK0_OFF), .UNLOCK1(UNLOCK1_OFF),
        .SECTOR_CYC(SECTOR_ERASE_CYCLES), .CHIP_CYC(CHIP_ERASE_CYCLES)
    ) u_fsm (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_byte(wr_data[7:0]),
        .word_off(wr_off), .state(state), .bypass(bypass_active),
        .status(status_byte), .op(op)
    );

    nor_cell_array #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SEC_W(SEC_W)) u_array (
        .clk(clk), .rst(rst), .op(op), .read_only(read_only),
        .wr_idx(wr_idx), .wr_sector(wr_sector), .wr_word(wr_data),
        .rd_idx(rd_idx), .rd_word(rd_data)
    );

    assign seq_state  = state;
    assign erase_busy = (state == ST_ERASING);
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
    import nor_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [7:0]        wr_byte,
    input logic              read_only,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [3:0]        seq_state,
    input logic              bypass_active,
    input logic              erase_busy,
    input logic [7:0]        status_byte
);
    a_r6_abort_to_read: assert property (@(posedge clk) disable iff (rst)
        $past(wr_valid && wr_byte == CMD_ABORT && seq_state != 4'(ST_PROGRAM))
        |-> (seq_state == 4'(ST_READ) && !bypass_active));

    a_r7_program_status: assert property (@(posedge clk) disable iff (rst)
        $past(wr_valid && seq_state == 4'(ST_PROGRAM) && !rst)
        |-> (status_byte == {~$past(wr_byte[7]), 7'h7F}));

    a_r8_bypass_kept: assert property (@(posedge clk) disable iff (rst)
        $past(wr_valid && seq_state == 4'(ST_PROGRAM) && bypass_active && !rst)
        |-> (seq_state == 4'(ST_COMMAND) && bypass_active));

    a_r10_erase_clears_status: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_busy) |-> (status_byte == 8'h00));

    a_r10_erase_done_flip: assert property (@(posedge clk) disable iff (rst)
        ($fell(erase_busy) && !$past(wr_valid && wr_byte == CMD_ABORT))
        |-> (status_byte == 8'h80));

    a_r12_frozen_array: assert property (@(posedge clk) disable iff (rst)
        (read_only && $past(read_only) && $stable(rd_addr) && !$past(rst))
        |-> $stable(rd_data));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_byte(wr_data[7:0]),
    .read_only(read_only), .rd_addr(rd_addr), .rd_data(rd_data),
    .seq_state(seq_state), .bypass_active(bypass_active),
    .erase_busy(erase_busy), .status_byte(status_byte)
);

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
    localparam int SC = 16;
    localparam int CC = 40;
    localparam int U0B = 'h154;   // word offset 0xAA, 16-bit device
    localparam int U1B = 'h0AA;   // word offset 0x55
    localparam int QRB = 'h0AA;   // query offset 0x55

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        read_only = 1'b0;
    logic [10:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  seq_state;
    logic        bypass_active, erase_busy;
    logic [7:0]  status_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    nor_cmd_seq #(
        .WIDTH_BYTES(2), .SECTOR_BYTES(512), .NUM_SECTORS(4),
        .UNLOCK0_OFF('hAA), .UNLOCK1_OFF('h55),
        .SECTOR_ERASE_CYCLES(SC), .CHIP_ERASE_CYCLES(CC)
    ) dut (.*);

    always #10 clk = ~clk;

    // behavioural reference model
    int m_state, m_byp, m_stat, m_tmr;
    int m_mem [1024];

    task automatic m_idle();
        m_state = 0; m_byp = 0;
    endtask

    always @(posedge clk) begin
        int off, c, sec;
        if (rst) begin
            m_idle(); m_stat = 0; m_tmr = 0;
            foreach (m_mem[i]) m_mem[i] = 'hFFFF;
        end else begin
            off = (int'(wr_addr) % 512) / 2;
            c   = int'(wr_data[7:0]);
            sec = int'(wr_addr) / 512;
            if (wr_valid && c == 'hF0 && m_state != 3) m_idle();
            else if (m_state == 8) begin
                if (m_tmr == 1) begin
                    m_stat = m_stat ^ 'h80;
                    m_state = m_byp ? 2 : 0;
                end else m_tmr--;
            end else if (wr_valid) begin
                case (m_state)
                    0: if (off == 'h55 && c == 'h98) m_state = 9;
                       else if (off == 'hAA && c == 'hAA) m_state = 1;
                       else m_idle();
                    1: if (off == 'h55 && c == 'h55) m_state = 2; else m_idle();
                    2: if (!m_byp && off != 'hAA) m_idle();
                       else if (c == 'h20) m_byp = 1;
                       else if (c == 'h80) m_state = 5;
                       else if (c == 'h90) m_state = 4;
                       else if (c == 'hA0) m_state = 3;
                       else m_idle();
                    3: begin
                        if (!read_only) m_mem[int'(wr_addr) / 2] &= int'(wr_data);
                        m_stat = ((wr_data[7]) ? 0 : 'h80) | 'h7F;
                        m_state = m_byp ? 2 : 0;
                    end
                    4: if (!(m_byp && c == 0) && off == 'h55 && c == 'h98) begin
                           m_state = 9; m_byp = 0;
                       end else m_idle();
                    5: if (off == 'hAA && c == 'hAA) m_state = 6; else m_idle();
                    6: if (off == 'h55 && c == 'h55) m_state = 7; else m_idle();
                    7: if (c == 'h10 && off == 'hAA) begin
                           if (!read_only) foreach (m_mem[i]) m_mem[i] = 'hFFFF;
                           m_stat = 0; m_tmr = CC; m_state = 8;
                       end else if (c == 'h30) begin
                           if (!read_only)
                               for (int i = sec * 256; i < sec * 256 + 256; i++) m_mem[i] = 'hFFFF;
                           m_stat = 0; m_tmr = SC; m_state = 8;
                       end else m_idle();
                    default: m_idle();
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #5;
        if (!rst && !finished) begin
            chk("R2 model state", int'(seq_state), m_state);
            chk("R11 model bypass", int'(bypass_active), m_byp);
            chk("R10 model busy", int'(erase_busy), int'(m_state == 8));
            chk("R7 model status", int'(status_byte), m_stat);
            chk("R13 model rd_data", int'(rd_data), m_mem[int'(rd_addr) / 2]);
        end
    end

    task automatic wr(input int a, input int d);
        wr_valid = 1'b1; wr_addr = 11'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic unlock();
        wr(U0B, 'hAA); wr(U1B, 'h55);
    endtask

    task automatic peek(input int a, output int v);
        rd_addr = 11'(a); #1; v = int'(rd_data);
    endtask

    task automatic erase_seq(input int c, input int a);
        unlock(); wr(U0B, 'h80); unlock(); wr(a, c);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        chk("R1 reset state", int'(seq_state), 0);
        chk("R1 reset status", int'(status_byte), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(erase_busy), 0);
        peek('h3FE, v); chk("R1 array erased", v, 'hFFFF);

        // program, then AND over it
        unlock(); wr(U0B, 'hA0); wr('h010, 'h1234);
        peek('h010, v); chk("R7 first program", v, 'h1234);
        chk("R7 status bit7 clear data", int'(status_byte), 'hFF);
        chk("R8 program returns read", int'(seq_state), 0);
        unlock(); wr(U0B, 'hA0); wr('h010, 'h0F80);
        peek('h010, v); chk("R7 AND semantics", v, 'h0200);
        chk("R7 status bit7 set data", int'(status_byte), 'h7F);

        // 0xF0 in the data cycle is data
        unlock(); wr(U0B, 'hA0); wr('h020, 'h00F0);
        peek('h020, v); chk("R6 F0 as program data", v, 'h00F0);
        // 0xF0 mid-unlock
        wr(U0B, 'hAA); chk("R2 first unlock", int'(seq_state), 1);
        wr('h000, 'hF0); chk("R6 F0 abort", int'(seq_state), 0);
        // bad second unlock, bad command
        wr(U0B, 'hAA); wr('h002, 'h55); chk("R2 bad unlock", int'(seq_state), 0);
        unlock(); chk("R2 command state", int'(seq_state), 2);
        wr(U0B, 'h77); chk("R3 unknown command", int'(seq_state), 0);
        unlock(); wr('h000, 'hA0); chk("R3 wrong command offset", int'(seq_state), 0);
        // offset decoding: odd byte and other sector still match
        wr(U0B + 1 + 2 * 512, 'hAA); chk("R4 offset ignores sector/low bit", int'(seq_state), 1);
        wr('h000, 'hF0);

        // query entry and exit
        wr(QRB, 'h98); chk("R5 query from read", int'(seq_state), 9);
        wr('h000, 'h12); chk("R5 write leaves query", int'(seq_state), 0);
        unlock(); wr(U0B, 'h90); chk("R3 autoselect", int'(seq_state), 4);
        wr(QRB, 'h98); chk("R5 query from autoselect", int'(seq_state), 9);
        wr('h000, 'hF0);

        // sector erase of sector 1
        unlock(); wr(U0B, 'hA0); wr('h210, 'h5A5A);
        erase_seq('h30, 'h300);
        chk("R10 status cleared at erase", int'(status_byte), 0);
        chk("R10 busy at erase", int'(erase_busy), 1);
        wr(U0B, 'hAA); chk("R10 write ignored while busy", int'(seq_state), 8);
        repeat (SC - 2) @(negedge clk);
        chk("R10 still busy at last cycle", int'(erase_busy), 1);
        @(negedge clk);
        chk("R10 busy ends", int'(erase_busy), 0);
        chk("R10 status bit7 flipped", int'(status_byte), 'h80);
        chk("R10 back to read", int'(seq_state), 0);
        peek('h210, v); chk("R9 sector erased", v, 'hFFFF);
        peek('h010, v); chk("R9 other sector kept", v, 'h0200);

        // chip erase with wrong offset, then right one
        erase_seq('h10, 'h000); chk("R9 chip erase wrong offset", int'(seq_state), 0);
        erase_seq('h10, U0B);
        repeat (CC - 1) @(negedge clk);
        chk("R10 chip busy window", int'(erase_busy), 1);
        @(negedge clk);
        chk("R10 chip done", int'(erase_busy), 0);
        peek('h010, v); chk("R9 chip erased", v, 'hFFFF);

        // bypass
        unlock(); wr(U0B, 'h20);
        chk("R11 bypass set", int'(bypass_active), 1);
        wr('h400, 'hA0); wr('h400, 'h1111);
        chk("R8 bypass after program", int'(seq_state), 2);
        peek('h400, v); chk("R11 bypass program", v, 'h1111);
        wr('h000, 'h80); unlock(); wr('h200, 'h30);
        repeat (SC) @(negedge clk);
        chk("R10 erase ends in command under bypass", int'(seq_state), 2);
        chk("R11 bypass survives erase", int'(bypass_active), 1);
        wr('h000, 'h90); wr('h000, 'h00);
        chk("R11 bypass exit", int'(bypass_active), 0);
        chk("R11 exit to read", int'(seq_state), 0);

        // read-only
        read_only = 1'b1;
        unlock(); wr(U0B, 'hA0); wr('h030, 'h0000);
        peek('h030, v); chk("R12 program blocked", v, 'hFFFF);
        chk("R12 status still updates", int'(status_byte), 'hFF);
        erase_seq('h30, 'h400);
        repeat (SC) @(negedge clk);
        peek('h400, v); chk("R12 erase blocked", v, 'h1111);
        read_only = 1'b0;

        // abort an erase with 0xF0
        erase_seq('h30, 'h600); wr('h000, 'hF0);
        chk("R6 abort erase", int'(erase_busy), 0);
        chk("R6 abort keeps status", int'(status_byte), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule